// File: doc/BRIEF.md
# Single-Cycle Integer Core

A small processor core that finishes one instruction in every clock. Each cycle it presents its program counter to an instruction memory, which returns a 32-bit word without delay. The core decodes that word, reads two source registers, runs the arithmetic unit and writes the result into a 32-entry register file on the same clock edge. It then moves the program counter to the next word. The instruction set is a 32-bit subset with three-register arithmetic, logic and shift operations and four immediate instructions (two adds and two compares). Decoding goes through a per-opcode control word. Every opcode whose word lacks the "supported" flag stops the core.

Each retired instruction appears one cycle later on a registered write-back port, so a system or a bench can follow the architectural state. A fault stops the core: an undefined opcode or function code, or a signed overflow on the trapping adds and subtract. The core then freezes the program counter and the register file, and it raises a sticky trap flag with a cause code. Only a synchronous reset clears it.

Top module: `sc_core`

## Requirements
- R1: While and just after `rst` is high, `imem_addr` is 0, `trap` is 0, `trap_cause` is 0 and `wb_valid` is 0.
- R2: Each cycle without a fault and with no trap pending, `imem_addr` advances by 4.
- R3: Opcode 0 selects the operation from the function field (bits 5:0). The codes are 0 shift-left by shamt (bits 10:6), 2 logical right, 3 arithmetic right, 4/6/7 the same three shifts by rs[4:0], 32 add, 33 add without trap, 34 subtract, 35 subtract without trap, 36 and, 37 or, 38 xor, 39 nor, 42 signed less-than, 43 unsigned less-than. The shifts act on rt, and the compares give 1 or 0.
- R4: Opcodes 8, 9, 10 and 11 compute rs plus the immediate (trapping), rs plus the immediate (non-trapping), signed less-than and unsigned less-than. The 16-bit immediate (bits 15:0) is sign-extended first in all four cases.
- R5: Opcode-0 results go to rd (bits 15:11). Immediate results go to rt (bits 20:16). rs is bits 25:21.
- R6: Register 0 always reads as zero. A write aimed at it changes nothing and raises no `wb_valid`.
- R7: Several encodings are undefined: any opcode other than 0 and 8 to 11, and any opcode-0 function code not listed in R3. Such an instruction sets `trap` with `trap_cause` = 1 and writes nothing.
- R8: Signed overflow on function 32, function 34 or opcode 8 sets `trap` with `trap_cause` = 2 and writes nothing. Functions 33 and 35 and opcode 9 wrap without trapping.
- R9: Once `trap` is set, it stays set with the same cause. `imem_addr` holds, and `wb_valid` stays low until reset.
- R10: One cycle after an instruction writes a non-zero register, `wb_valid` is 1 and `wb_idx`/`wb_data` carry the destination and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Byte address of the instruction being executed |
| imem_rdata | input | XLEN | Instruction word at `imem_addr`, same cycle |
| wb_valid | output | 1 | A register was written at the last edge |
| wb_idx | output | 5 | Index of the register written |
| wb_data | output | XLEN | Value written |
| trap | output | 1 | Sticky fault flag |
| trap_cause | output | 2 | 0 none, 1 undefined instruction, 2 signed overflow |

## Verification
An instruction presented on `imem_rdata` is fully executed at the next rising edge. Its write-back, the new `imem_addr` and any trap are therefore all visible one edge after the word was presented. The bench advances its behavioural model by one instruction before each rising edge. It compares all outputs at the following falling edge, so every result is checked in exactly the cycle it is due. After a trap, the bench keeps comparing for several more cycles to confirm the frozen state.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int OPC_W  = 6;
  localparam int NOPC   = 1 << OPC_W;
  localparam int REG_AW = 5;
  localparam int CTRL_W = 7;

  // control word bit positions
  localparam int CB_SUP = 0;
  localparam int CB_M2R = 1;
  localparam int CB_MW  = 2;
  localparam int CB_IMM = 3;
  localparam int CB_RD  = 4;
  localparam int CB_RW  = 5;
  localparam int CB_BR  = 6;

  typedef logic [CTRL_W-1:0] ctrl_t;

  typedef enum logic [4:0] {
    OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV,
    OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
    OP_AND, OP_OR, OP_XOR, OP_NOR, OP_SLT, OP_SLTU
  } alu_op_e;

  typedef enum logic [1:0] {
    TC_NONE  = 2'd0,
    TC_UNSUP = 2'd1,
    TC_OVF   = 2'd2
  } cause_e;

  function automatic ctrl_t ctrl_for(logic [OPC_W-1:0] opc);
    ctrl_t c;
    c = '0;
    case (opc)
      6'd0: begin
        c[CB_SUP] = 1'b1;
        c[CB_RD]  = 1'b1;
        c[CB_RW]  = 1'b1;
      end
      6'd8, 6'd9, 6'd10, 6'd11: begin
        c[CB_SUP] = 1'b1;
        c[CB_IMM] = 1'b1;
        c[CB_RW]  = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl,
  output alu_op_e         op,
  output logic            illegal
);
  logic [OPC_W-1:0] opc;
  logic [5:0]       fn;
  ctrl_t            rom [NOPC];
  logic             fn_ok;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  for (genvar g = 0; g < NOPC; g++) begin : g_rom
    assign rom[g] = ctrl_for(OPC_W'(g));
  end

  assign ctrl = rom[opc];

  always_comb begin
    op    = OP_ADDU;
    fn_ok = 1'b1;
    if (opc == '0) begin
      case (fn)
        6'd0:  op = OP_SLL;
        6'd2:  op = OP_SRL;
        6'd3:  op = OP_SRA;
        6'd4:  op = OP_SLLV;
        6'd6:  op = OP_SRLV;
        6'd7:  op = OP_SRAV;
        6'd32: op = OP_ADD;
        6'd33: op = OP_ADDU;
        6'd34: op = OP_SUB;
        6'd35: op = OP_SUBU;
        6'd36: op = OP_AND;
        6'd37: op = OP_OR;
        6'd38: op = OP_XOR;
        6'd39: op = OP_NOR;
        6'd42: op = OP_SLT;
        6'd43: op = OP_SLTU;
        default: fn_ok = 1'b0;
      endcase
    end else begin
      case (opc)
        6'd8:    op = OP_ADD;
        6'd9:    op = OP_ADDU;
        6'd10:   op = OP_SLT;
        6'd11:   op = OP_SLTU;
        default: op = OP_ADDU;
      endcase
    end
  end

  // flags for datapath pieces this core lacks are treated as undefined
  assign illegal = !ctrl[CB_SUP] || !fn_ok ||
                   ctrl[CB_M2R] || ctrl[CB_MW] || ctrl[CB_BR];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] y,
  output logic            ovf
);
  logic [XLEN:0] sum, dif;
  logic [SHW-1:0] vsh;

  assign sum = {a[XLEN-1], a} + {b[XLEN-1], b};
  assign dif = {a[XLEN-1], a} - {b[XLEN-1], b};
  assign vsh = a[SHW-1:0];

  always_comb begin
    ovf = 1'b0;
    case (op)
      OP_SLL:  y = b << shamt;
      OP_SRL:  y = b >> shamt;
      OP_SRA:  y = $unsigned($signed(b) >>> shamt);
      OP_SLLV: y = b << vsh;
      OP_SRLV: y = b >> vsh;
      OP_SRAV: y = $unsigned($signed(b) >>> vsh);
      OP_ADD:  begin y = sum[XLEN-1:0]; ovf = sum[XLEN] ^ sum[XLEN-1]; end
      OP_ADDU: y = sum[XLEN-1:0];
      OP_SUB:  begin y = dif[XLEN-1:0]; ovf = dif[XLEN] ^ dif[XLEN-1]; end
      OP_SUBU: y = dif[XLEN-1:0];
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      OP_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      OP_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [XLEN-1:0]   imem_rdata,
  output logic              wb_valid,
  output logic [REG_AW-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              trap,
  output logic [1:0]        trap_cause
);
  localparam int NREG    = 1 << REG_AW;
  localparam int PC_STEP = XLEN / 8;

  logic [PC_W-1:0]   pc_q;
  logic              trap_q;
  cause_e            cause_q;

  ctrl_t             ctrl;
  alu_op_e           op;
  logic              dec_illegal;
  logic [REG_AW-1:0] rs, rt, rd, dest;
  logic [XLEN-1:0]   rs_val, rt_val, imm_x, opnd_b, alu_y;
  logic              alu_ovf, fault, wr_en;

  assign rs    = imem_rdata[25:21];
  assign rt    = imem_rdata[20:16];
  assign rd    = imem_rdata[15:11];
  assign imm_x = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

  sc_decode #(.XLEN(XLEN)) u_dec (
    .instr(imem_rdata), .ctrl(ctrl), .op(op), .illegal(dec_illegal)
  );

  sc_regfile #(.XLEN(XLEN), .DEPTH(NREG)) u_rf (
    .clk(clk), .we(wr_en), .waddr(dest), .wdata(alu_y),
    .raddr_a(rs), .rdata_a(rs_val), .raddr_b(rt), .rdata_b(rt_val)
  );

  assign opnd_b = ctrl[CB_IMM] ? imm_x : rt_val;
  assign dest   = ctrl[CB_RD] ? rd : rt;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .op(op), .a(rs_val), .b(opnd_b), .shamt(imem_rdata[10:6]),
    .y(alu_y), .ovf(alu_ovf)
  );

  assign fault = dec_illegal || alu_ovf;
  assign wr_en = !rst && !trap_q && !fault && ctrl[CB_RW] && (dest != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      trap_q   <= 1'b0;
      cause_q  <= TC_NONE;
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else if (trap_q) begin
      wb_valid <= 1'b0;
    end else if (fault) begin
      trap_q   <= 1'b1;
      cause_q  <= dec_illegal ? TC_UNSUP : TC_OVF;
      wb_valid <= 1'b0;
    end else begin
      pc_q     <= pc_q + PC_W'(PC_STEP);
      wb_valid <= wr_en;
      wb_idx   <= dest;
      wb_data  <= alu_y;
    end
  end

  assign imem_addr  = pc_q;
  assign trap       = trap_q;
  assign trap_cause = cause_q;

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!trap_q && !fault) |=> (pc_q == $past(pc_q) + PC_W'(PC_STEP)));

  p_no_zero_wb_r6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_idx != '0));

  p_unsup_trap_r7: assert property (@(posedge clk) disable iff (rst)
    (!trap_q && dec_illegal) |=> (trap_q && cause_q == TC_UNSUP && !wb_valid));

  p_ovf_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (!trap_q && !dec_illegal && alu_ovf) |=> (trap_q && cause_q == TC_OVF && !wb_valid));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    trap_q |=> (trap_q && $stable(pc_q) && $stable(cause_q) && !wb_valid));
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, wb_data;
  logic        wb_valid, trap;
  logic [4:0]  wb_idx;
  logic [1:0]  trap_cause;

  logic [31:0] prog [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;
  logic        m_trapped;
  logic [1:0]  m_cause;
  logic        e_valid;
  logic [4:0]  e_idx;
  logic [31:0] e_data;
  string       e_tag;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  assign imem_rdata = prog[imem_addr[7:2]];

  sc_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .trap(trap), .trap_cause(trap_cause)
  );

  function automatic logic [31:0] rt_(int s, int t, int d, int sh, int fn);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] it_(int op, int s, int t, int imm);
    return {6'(op), 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
    end
  endtask

  // behavioural model: one instruction
  task automatic model_step();
    logic [31:0] ins, a, b, y;
    logic [5:0]  op, fn;
    logic [4:0]  dst;
    bit          unsup, ovf;
    longint      wide;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = (ins[25:21] == 0) ? 32'd0 : m_reg[ins[25:21]];
    b = (ins[20:16] == 0) ? 32'd0 : m_reg[ins[20:16]];
    unsup = 0; ovf = 0; y = 0; dst = 0;
    e_valid = 0;
    if (m_trapped) begin
      e_tag = "R9";
      return;
    end
    if (op == 0) begin
      e_tag = "R3"; dst = ins[15:11];
      case (fn)
        0:  y = b << ins[10:6];
        2:  y = b >> ins[10:6];
        3:  y = $signed(b) >>> ins[10:6];
        4:  y = b << a[4:0];
        6:  y = b >> a[4:0];
        7:  y = $signed(b) >>> a[4:0];
        32, 33: begin
          y = a + b;
          wide = longint'($signed(a)) + longint'($signed(b));
          ovf = (fn == 32) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
        end
        34, 35: begin
          y = a - b;
          wide = longint'($signed(a)) - longint'($signed(b));
          ovf = (fn == 34) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
        end
        36: y = a & b;
        37: y = a | b;
        38: y = a ^ b;
        39: y = ~(a | b);
        42: y = ($signed(a) < $signed(b)) ? 1 : 0;
        43: y = (a < b) ? 1 : 0;
        default: unsup = 1;
      endcase
    end else if (op >= 8 && op <= 11) begin
      e_tag = "R4"; dst = ins[20:16];
      b = {{16{ins[15]}}, ins[15:0]};
      case (op)
        8, 9: begin
          y = a + b;
          wide = longint'($signed(a)) + longint'($signed(b));
          ovf = (op == 8) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
        end
        10: y = ($signed(a) < $signed(b)) ? 1 : 0;
        default: y = (a < b) ? 1 : 0;
      endcase
    end else begin
      unsup = 1;
    end
    if (unsup) begin
      e_tag = "R7"; m_trapped = 1; m_cause = 1;
    end else if (ovf) begin
      e_tag = "R8"; m_trapped = 1; m_cause = 2;
    end else begin
      m_pc += 4;
      if (dst != 0) begin
        e_valid = 1; e_idx = dst; e_data = y; m_reg[dst] = y;
      end else begin
        e_tag = "R6";
      end
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
  endtask

  task automatic run(input int cycles);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    e_tag = "R1";
    chk(imem_addr == 0, "reset pc", imem_addr, 0);
    chk(!trap && trap_cause == 0, "reset trap", {trap, trap_cause}, 0);
    chk(!wb_valid, "reset wb_valid", wb_valid, 0);
    rst = 1'b0;
    m_pc = 0; m_trapped = 0; m_cause = 0;
    for (int c = 0; c < cycles; c++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(imem_addr == m_pc, "pc (R2)", imem_addr, m_pc);
      chk(trap == m_trapped && trap_cause == m_cause, "trap/cause",
          {trap, trap_cause}, {m_trapped, m_cause});
      chk(wb_valid == e_valid, "wb_valid (R10)", wb_valid, e_valid);
      if (e_valid) begin
        chk(wb_idx == e_idx, "wb_idx (R5)", wb_idx, e_idx);
        chk(wb_data == e_data, "wb_data", wb_data, e_data);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    clear_prog();
    // arithmetic, logic, shifts, compares, r0 handling, overflow at the end
    prog[0]  = it_(9, 0, 1, 5);
    prog[1]  = it_(9, 0, 2, -3);
    prog[2]  = rt_(1, 2, 3, 0, 33);
    prog[3]  = rt_(1, 2, 4, 0, 34);
    prog[4]  = rt_(1, 2, 5, 0, 36);
    prog[5]  = rt_(1, 2, 6, 0, 37);
    prog[6]  = rt_(1, 2, 7, 0, 38);
    prog[7]  = rt_(1, 2, 8, 0, 39);
    prog[8]  = rt_(2, 1, 9, 0, 42);
    prog[9]  = rt_(2, 1, 10, 0, 43);
    prog[10] = rt_(0, 1, 11, 4, 0);
    prog[11] = rt_(0, 2, 12, 1, 3);
    prog[12] = rt_(0, 2, 13, 28, 2);
    prog[13] = rt_(1, 1, 14, 0, 4);
    prog[14] = rt_(1, 2, 15, 0, 7);
    prog[15] = rt_(1, 2, 16, 0, 6);
    prog[16] = it_(10, 2, 17, -2);
    prog[17] = it_(11, 1, 18, -1);
    prog[18] = it_(11, 2, 19, 1);
    prog[19] = it_(8, 1, 20, -7);
    prog[20] = it_(9, 1, 0, 9);
    prog[21] = rt_(0, 0, 21, 0, 33);
    prog[22] = it_(9, 0, 22, 32'h7FFF);
    prog[23] = rt_(0, 22, 22, 16, 0);
    prog[24] = rt_(22, 22, 23, 0, 33);
    prog[25] = rt_(22, 22, 24, 0, 35);
    prog[26] = rt_(22, 22, 25, 0, 32);
    run(32);
    // undefined opcode (a load)
    clear_prog();
    prog[0] = it_(9, 0, 5, 1);
    prog[1] = it_(35, 0, 6, 0);
    run(5);
    // undefined function code
    clear_prog();
    prog[0] = rt_(1, 2, 3, 0, 1);
    run(3);
    // jump opcode
    clear_prog();
    prog[0] = it_(9, 0, 7, 2);
    prog[1] = {6'd2, 26'd4};
    run(4);
    // immediate add overflow, and subtract overflow
    clear_prog();
    prog[0] = it_(9, 0, 2, -1);
    prog[1] = rt_(0, 2, 2, 1, 2);
    prog[2] = it_(9, 2, 3, 1);
    prog[3] = it_(8, 2, 4, 1);
    run(6);
    clear_prog();
    prog[0] = it_(9, 0, 1, -2);
    prog[1] = rt_(0, 1, 1, 30, 0);
    prog[2] = it_(9, 0, 2, 1);
    prog[3] = rt_(1, 2, 3, 0, 34);
    run(6);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule